// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block keeps one pending-write bit for every register of a register file so that an in-order core can let instructions overlap. When an instruction issues and names a destination, a set request marks that register as owed a result. When the register-file write port is granted for that register, a clear request removes the mark. A unit that finishes without producing a result also removes the mark it left behind. Register numbers arrive either as binary indices or as one-hot masks, selected by a parameter.

The pending vector answers two kinds of query. A read-operand query reports a read-after-write hazard when any register the operand wants is still owed a result. A destination query reports a write-after-write hazard for the incoming instruction, and all destination queries are OR-ed into a single stall. Each read query runs a small state machine with the states Q_IDLE, Q_ARMED and Q_RELEASED. The transition arm (Q_IDLE to Q_ARMED) happens while the operand is active with its read flag set. The transition release (Q_ARMED to Q_RELEASED) happens when the owning unit is busy and no hazard is seen. The transition drop (Q_ARMED or Q_RELEASED to Q_IDLE) happens when the operand goes inactive.

Each unit tracker has the states U_IDLE and U_HELD. The transition latch (to U_HELD) happens on issue with the write flag set. The transition unlatch (to U_IDLE) happens on issue without the write flag, or when the unit is no longer busy.

Top module: `wps_scoreboard`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it, every pending bit is zero.
- R2: A set request in cycle T marks the register from the next cycle on. A read query of that same register in cycle T reports no hazard, so an instruction never stalls on itself.
- R3: A valid clear request in cycle T makes that register's pending bit zero from cycle T+1.
- R4: When set and clear name the same register in one cycle, the bit is 1 afterwards.
- R5: All set ports are OR-merged and all clear ports are OR-merged. Two ports naming different registers in one cycle both take effect, and neither overrides the other.
- R6: A set or clear port whose valid input is low changes no pending bit, whatever register number it carries.
- R7: A read query's hazard output is 1 exactly when the operand is active, its read flag is 1, its state is not Q_RELEASED and the requested register is pending. It is 0 otherwise.
- R8: Once a query takes the release transition (the unit is busy with no hazard in Q_ARMED), its hazard stays 0 even if the register later becomes pending, until the operand goes inactive.
- R9: Each destination query outputs 1 when it is valid and its register is pending. The stall output is the OR of all destination query outputs. An invalid destination query outputs 0.
- R10: A unit that issued with its write flag set and later reports done with result-valid low clears the pending bit of its latched destination, visible the next cycle. With result-valid high, done clears nothing.
- R11: When a held unit sees busy low, its latch is dropped (unlatch), and a later done with result-valid low clears nothing.
- R12: With ONE_HOT=0, a register field holding the value n selects pending bit n (mask 1<<n). With ONE_HOT=1, the field is used directly as the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_vld | input | NS | Per set port: issue-time mark request |
| set_reg | input | NS*RW | Per set port: destination register field |
| clr_vld | input | NC | Per clear port: write-port grant |
| clr_reg | input | NC*RW | Per clear port: register being written |
| u_issue | input | NU | Per unit: issue strobe |
| u_wrflag | input | NU | Per unit: instruction writes a register |
| u_dest | input | NU*RW | Per unit: destination register field |
| u_busy | input | NU | Per unit: unit busy |
| u_done | input | NU | Per unit: computation done |
| u_resok | input | NU | Per unit: result valid, a write will follow |
| rq_active | input | NQ | Per read query: owning unit active |
| rq_rdflag | input | NQ | Per read query: operand is read |
| rq_busy | input | NQ | Per read query: owning unit busy |
| rq_reg | input | NQ*RW | Per read query: source register field |
| rq_hazard | output | NQ | Per read query: read-after-write hazard |
| ww_vld | input | NW | Per destination query: valid |
| ww_reg | input | NW*RW | Per destination query: destination register field |
| ww_hit | output | NW | Per destination query: write-after-write hazard |
| ww_stall | output | 1 | OR of all destination hazards |
| pending | output | NR | Pending-write vector |

## Verification
A wrong bit in the pending array shows on the `pending` output one edge after the faulty update. It also shows in the same cycle on every read or destination query that names that register. A lost clear leaves a permanent hazard. A lost or late set shows up as a missing hazard in the cycle after issue. A query state machine stuck in Q_RELEASED or Q_ARMED is exposed by a single stimulus, because the hazard output differs between those states when the register is pending. A unit tracker that holds or drops its latch wrongly shows one cycle after the done strobe, as a pending bit that stays set or is cleared.

// File: rtl/wps_pkg.sv
package wps_pkg;

    typedef enum logic [1:0] {
        Q_IDLE     = 2'd0,
        Q_ARMED    = 2'd1,
        Q_RELEASED = 2'd2
    } q_state_e;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_HELD = 1'b1
    } u_state_e;

    function automatic int field_width(input int nregs, input int one_hot);
        return (one_hot != 0) ? nregs : $clog2(nregs);
    endfunction

endpackage

// File: rtl/wps_req_decode.sv
module wps_req_decode #(
    parameter int NR      = 8,
    parameter int ONE_HOT = 0,
    parameter int RW      = 3
) (
    input  logic          vld,
    input  logic [RW-1:0] req,
    output logic [NR-1:0] mask
);
    generate
        if (ONE_HOT != 0) begin : g_onehot
            always_comb begin
                mask = '0;
                for (int k = 0; k < NR; k++) begin
                    mask[k] = vld & req[k];
                end
            end
        end else begin : g_binary
            always_comb begin
                mask = '0;
                for (int k = 0; k < NR; k++) begin
                    mask[k] = vld && (req == RW'(k));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wps_unit_tracker.sv
module wps_unit_tracker
    import wps_pkg::*;
#(
    parameter int NR      = 8,
    parameter int ONE_HOT = 0,
    parameter int RW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          wrflag,
    input  logic [RW-1:0] dest,
    input  logic          busy,
    input  logic          done,
    input  logic          resok,
    output logic [NR-1:0] clr_mask
);
    u_state_e      state_q, state_d;
    logic [RW-1:0] dest_q;
    logic          fire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            dest_q  <= '0;
        end else begin
            state_q <= state_d;
            if (issue && wrflag) dest_q <= dest;
        end
    end

    // transitions: latch / unlatch
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (issue && wrflag) state_d = U_HELD;
            U_HELD: begin
                if (issue)      state_d = wrflag ? U_HELD : U_IDLE;
                else if (!busy) state_d = U_IDLE;
            end
            default: state_d = U_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire = (state_q == U_HELD) && done && !resok;
    end

    wps_req_decode #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_dec (
        .vld (fire),
        .req (dest_q),
        .mask(clr_mask)
    );
endmodule

// File: rtl/wps_read_query.sv
module wps_read_query
    import wps_pkg::*;
#(
    parameter int NR      = 8,
    parameter int ONE_HOT = 0,
    parameter int RW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rdflag,
    input  logic          busy,
    input  logic [RW-1:0] src,
    input  logic [NR-1:0] pend,
    output logic          hazard
);
    q_state_e      state_q, state_d;
    logic          gate;
    logic [NR-1:0] mask;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm / release / drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_IDLE:     if (active && rdflag) state_d = Q_ARMED;
            Q_ARMED: begin
                if (!(active && rdflag))  state_d = Q_IDLE;
                else if (busy && !hazard) state_d = Q_RELEASED;
            end
            Q_RELEASED: if (!active) state_d = Q_IDLE;
            default:    state_d = Q_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gate   = active && rdflag && (state_q != Q_RELEASED);
        hazard = |(pend & mask);
    end

    wps_req_decode #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_dec (
        .vld (gate),
        .req (src),
        .mask(mask)
    );
endmodule

// File: rtl/wps_scoreboard.sv
module wps_scoreboard
    import wps_pkg::*;
#(
    parameter int NR      = 8,
    parameter int NS      = 2,
    parameter int NC      = 2,
    parameter int NU      = 2,
    parameter int NQ      = 2,
    parameter int NW      = 2,
    parameter int ONE_HOT = 0,
    localparam int RW     = field_width(NR, ONE_HOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   set_vld,
    input  logic [NS*RW-1:0] set_reg,
    input  logic [NC-1:0]   clr_vld,
    input  logic [NC*RW-1:0] clr_reg,
    input  logic [NU-1:0]   u_issue,
    input  logic [NU-1:0]   u_wrflag,
    input  logic [NU*RW-1:0] u_dest,
    input  logic [NU-1:0]   u_busy,
    input  logic [NU-1:0]   u_done,
    input  logic [NU-1:0]   u_resok,
    input  logic [NQ-1:0]   rq_active,
    input  logic [NQ-1:0]   rq_rdflag,
    input  logic [NQ-1:0]   rq_busy,
    input  logic [NQ*RW-1:0] rq_reg,
    output logic [NQ-1:0]   rq_hazard,
    input  logic [NW-1:0]   ww_vld,
    input  logic [NW*RW-1:0] ww_reg,
    output logic [NW-1:0]   ww_hit,
    output logic            ww_stall,
    output logic [NR-1:0]   pending
);
    logic [NR-1:0] set_m  [NS];
    logic [NR-1:0] clr_m  [NC];
    logic [NR-1:0] unit_m [NU];
    logic [NR-1:0] ww_m   [NW];
    logic [NR-1:0] set_vec, clr_vec;

    genvar gi;
    generate
        for (gi = 0; gi < NS; gi++) begin : g_set
            wps_req_decode #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_dec (
                .vld(set_vld[gi]), .req(set_reg[gi*RW +: RW]), .mask(set_m[gi]));
        end
        for (gi = 0; gi < NC; gi++) begin : g_clr
            wps_req_decode #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_dec (
                .vld(clr_vld[gi]), .req(clr_reg[gi*RW +: RW]), .mask(clr_m[gi]));
        end
        for (gi = 0; gi < NU; gi++) begin : g_unit
            wps_unit_tracker #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_trk (
                .clk(clk), .rst_n(rst_n),
                .issue(u_issue[gi]), .wrflag(u_wrflag[gi]),
                .dest(u_dest[gi*RW +: RW]), .busy(u_busy[gi]),
                .done(u_done[gi]), .resok(u_resok[gi]),
                .clr_mask(unit_m[gi]));
        end
        for (gi = 0; gi < NQ; gi++) begin : g_rq
            wps_read_query #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_q (
                .clk(clk), .rst_n(rst_n),
                .active(rq_active[gi]), .rdflag(rq_rdflag[gi]),
                .busy(rq_busy[gi]), .src(rq_reg[gi*RW +: RW]),
                .pend(pending), .hazard(rq_hazard[gi]));
        end
        for (gi = 0; gi < NW; gi++) begin : g_ww
            wps_req_decode #(.NR(NR), .ONE_HOT(ONE_HOT), .RW(RW)) u_dec (
                .vld(ww_vld[gi]), .req(ww_reg[gi*RW +: RW]), .mask(ww_m[gi]));
        end
    endgenerate

    // OR-merge of every request source
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < NS; i++) set_vec = set_vec | set_m[i];
        for (int i = 0; i < NC; i++) clr_vec = clr_vec | clr_m[i];
        for (int i = 0; i < NU; i++) clr_vec = clr_vec | unit_m[i];
    end

    // pending array: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_vec) | set_vec;
    end

    // destination queries
    always_comb begin
        for (int i = 0; i < NW; i++) ww_hit[i] = |(pending & ww_m[i]);
        ww_stall = |ww_hit;
    end
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
    parameter int NR = 8,
    parameter int NQ = 2,
    parameter int NW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NR-1:0] pending,
    input logic [NR-1:0] set_vec,
    input logic [NR-1:0] clr_vec,
    input logic [NQ-1:0] rq_active,
    input logic [NQ-1:0] rq_rdflag,
    input logic [NQ-1:0] rq_hazard,
    input logic [NW-1:0] ww_vld,
    input logic [NW-1:0] ww_hit,
    input logic          ww_stall
);
    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> pending == '0); // R1
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec))); // R4
    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((pending & $past(clr_vec & ~set_vec)) == '0)); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((pending & ~$past(pending) & ~$past(set_vec)) == '0)); // R5
    AST_RQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_hazard & ~(rq_active & rq_rdflag)) == '0); // R7
    AST_WW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((ww_hit & ~ww_vld) == '0) && (ww_stall == (ww_hit != '0))); // R9
endmodule

bind wps_scoreboard wps_checker #(.NR(NR), .NQ(NQ), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pending(pending),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .rq_active(rq_active), .rq_rdflag(rq_rdflag), .rq_hazard(rq_hazard),
    .ww_vld(ww_vld), .ww_hit(ww_hit), .ww_stall(ww_stall));

// File: tb/sim_wps_scoreboard.sv
`timescale 1ns/1ps
module sim_wps_scoreboard;
    localparam int NR = 8, NS = 2, NC = 2, NU = 2, NQ = 2, NW = 2, RW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [NS-1:0] set_vld;    logic [NS*RW-1:0] set_reg;
    logic [NC-1:0] clr_vld;    logic [NC*RW-1:0] clr_reg;
    logic [NU-1:0] u_issue, u_wrflag, u_busy, u_done, u_resok;
    logic [NU*RW-1:0] u_dest;
    logic [NQ-1:0] rq_active, rq_rdflag, rq_busy, rq_hazard;
    logic [NQ*RW-1:0] rq_reg;
    logic [NW-1:0] ww_vld, ww_hit;
    logic [NW*RW-1:0] ww_reg;
    logic ww_stall;
    logic [NR-1:0] pending;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wps_scoreboard #(.NR(NR), .NS(NS), .NC(NC), .NU(NU), .NQ(NQ), .NW(NW), .ONE_HOT(0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_reg(set_reg), .clr_vld(clr_vld), .clr_reg(clr_reg),
        .u_issue(u_issue), .u_wrflag(u_wrflag), .u_dest(u_dest), .u_busy(u_busy),
        .u_done(u_done), .u_resok(u_resok),
        .rq_active(rq_active), .rq_rdflag(rq_rdflag), .rq_busy(rq_busy),
        .rq_reg(rq_reg), .rq_hazard(rq_hazard),
        .ww_vld(ww_vld), .ww_reg(ww_reg), .ww_hit(ww_hit), .ww_stall(ww_stall),
        .pending(pending));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        set_vld = '0; set_reg = '0; clr_vld = '0; clr_reg = '0;
        u_issue = '0; u_wrflag = '0; u_dest = '0; u_busy = '0; u_done = '0; u_resok = '0;
        rq_active = '0; rq_rdflag = '0; rq_busy = '0; rq_reg = '0;
        ww_vld = '0; ww_reg = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        set_vld = 2'b11; set_reg = {3'd4, 3'd1};
        repeat (3) tick();
        chk("R1 pending in reset", 32'(pending), 0);
        idle_inputs();
        rst_n = 1'b1;
        tick();
        chk("R1 pending after reset", 32'(pending), 0);

        // Sweep: set via port 0, self-read in issue cycle, query every reg, clear via port 1
        for (int r = 0; r < NR; r++) begin
            set_vld[0] = 1'b1; set_reg[2:0] = 3'(r);
            rq_active[0] = 1'b1; rq_rdflag[0] = 1'b1; rq_reg[2:0] = 3'(r);
            #1 chk("R2 no self hazard in issue cycle", 32'(rq_hazard[0]), 0);
            tick();
            set_vld = '0;
            #1 chk("R12 binary index selects bit", 32'(pending), 32'(1) << r);
            chk("R2 hazard next cycle", 32'(rq_hazard[0]), 1);
            for (int q = 0; q < NR; q++) begin
                rq_reg[2:0] = 3'(q);
                #1 chk("R7 read hazard per register", 32'(rq_hazard[0]), (q == r) ? 1 : 0);
            end
            clr_vld[1] = 1'b1; clr_reg[5:3] = 3'(r);
            tick();
            clr_vld = '0;
            #1 chk("R3 clear lands next cycle", 32'(pending), 0);
        end

        // R7: read flag low / inactive gives no hazard
        set_vld[0] = 1'b1; set_reg[2:0] = 3'd3; tick(); set_vld = '0;
        rq_reg[2:0] = 3'd3; rq_rdflag[0] = 1'b0;
        #1 chk("R7 rdflag low", 32'(rq_hazard[0]), 0);
        rq_rdflag[0] = 1'b1; rq_active[0] = 1'b0;
        #1 chk("R7 inactive", 32'(rq_hazard[0]), 0);
        rq_active[0] = 1'b0; rq_rdflag[0] = 1'b0;

        // R4: set and clear same register in one cycle
        set_vld[0] = 1'b1; set_reg[2:0] = 3'd3; clr_vld[0] = 1'b1; clr_reg[2:0] = 3'd3;
        tick(); idle_inputs();
        #1 chk("R4 set wins", 32'(pending), 32'h08);
        set_vld[1] = 1'b1; set_reg[5:3] = 3'd6; clr_vld[1] = 1'b1; clr_reg[5:3] = 3'd3;
        tick(); idle_inputs();
        #1 chk("R4 clear other, set new", 32'(pending), 32'h40);

        // R6: invalid ports
        set_reg = {3'd1, 3'd4}; clr_reg = {3'd6, 3'd6};
        tick(); idle_inputs();
        #1 chk("R6 invalid ports ignored", 32'(pending), 32'h40);

        // R5: two set ports, then two clear ports
        set_vld = 2'b11; set_reg = {3'd5, 3'd2};
        tick(); idle_inputs();
        #1 chk("R5 two sets merge", 32'(pending), 32'h64);
        clr_vld = 2'b11; clr_reg = {3'd2, 3'd6};
        tick(); idle_inputs();
        #1 chk("R5 two clears merge", 32'(pending), 32'h20);
        set_vld = 2'b11; set_reg = {3'd7, 3'd7}; clr_vld = 2'b01; clr_reg = {3'd0, 3'd5};
        tick(); idle_inputs();
        #1 chk("R5 same-reg sets with clear", 32'(pending), 32'h80);

        // R9: destination query sweep over pending = 0x80
        for (int r = 0; r < NR; r++) begin
            ww_vld = 2'b01; ww_reg = {3'd0, 3'(r)};
            #1 chk("R9 waw hit per register", 32'(ww_hit), (r == 7) ? 1 : 0);
            chk("R9 stall follows hit", 32'(ww_stall), (r == 7) ? 1 : 0);
        end
        ww_vld = 2'b10; ww_reg = {3'd7, 3'd7};
        #1 chk("R9 second port only", 32'(ww_hit), 2);
        ww_vld = 2'b00;
        #1 chk("R9 invalid gives no stall", {31'd0, ww_stall}, 0);
        clr_vld = 2'b01; clr_reg = {3'd0, 3'd7};
        tick(); idle_inputs();

        // R8: release sequence on query port 1
        rq_active[1] = 1'b1; rq_rdflag[1] = 1'b1; rq_reg[5:3] = 3'd2;
        tick();  // arm
        rq_busy[1] = 1'b1;
        tick();  // release
        set_vld[0] = 1'b1; set_reg[2:0] = 3'd2;
        tick(); set_vld = '0;
        #1 chk("R8 released ignores new pending", 32'(rq_hazard[1]), 0);
        chk("R8 pending really set", 32'(pending), 32'h04);
        rq_active[1] = 1'b0;
        tick();  // drop
        rq_active[1] = 1'b1;
        #1 chk("R8 re-armed sees hazard", 32'(rq_hazard[1]), 1);
        tick();  // arm with hazard: must stay armed
        #1 chk("R8 busy with hazard stays armed", 32'(rq_hazard[1]), 1);
        idle_inputs();
        clr_vld[0] = 1'b1; clr_reg[2:0] = 3'd2;
        tick(); idle_inputs();

        // R10: unit finishes without writing
        u_issue[0] = 1'b1; u_wrflag[0] = 1'b1; u_dest[2:0] = 3'd5; u_busy[0] = 1'b1;
        set_vld[0] = 1'b1; set_reg[2:0] = 3'd5;
        tick();
        u_issue = '0; set_vld = '0;
        #1 chk("R10 dest pending", 32'(pending), 32'h20);
        u_done[0] = 1'b1; u_resok[0] = 1'b1;
        tick();
        #1 chk("R10 done with result keeps bit", 32'(pending), 32'h20);
        u_resok[0] = 1'b0;
        tick();
        u_done = '0;
        #1 chk("R10 done without result clears", 32'(pending), 0);
        idle_inputs(); tick();

        // R11: latch dropped when busy goes low
        u_issue[1] = 1'b1; u_wrflag[1] = 1'b1; u_dest[5:3] = 3'd6; u_busy[1] = 1'b1;
        set_vld[0] = 1'b1; set_reg[2:0] = 3'd6;
        tick();
        u_issue = '0; set_vld = '0; u_busy[1] = 1'b0;
        tick();
        u_done[1] = 1'b1; u_resok[1] = 1'b0;
        tick();
        idle_inputs();
        #1 chk("R11 unlatched unit clears nothing", 32'(pending), 32'h40);
        // issue without write flag does not latch either
        u_issue[0] = 1'b1; u_wrflag[0] = 1'b0; u_dest[2:0] = 3'd6; u_busy[0] = 1'b1;
        tick();
        u_issue = '0; u_done[0] = 1'b1;
        tick();
        idle_inputs();
        #1 chk("R11 no write flag, no clear", 32'(pending), 32'h40);

        tick();
        finish_run();
    end
endmodule